// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Control Register

This block is one 64-bit control register that lets up to four processors signal each other and acknowledge a shared periodic timer. A processor posts an inter-processor interrupt (IPI) to any subset of the four processors by writing one-hot request bits. The target acknowledges it by writing one-hot clear bits. Each target keeps a small pending counter, so its IPI line stays high until it has been acknowledged as many times as it was requested. An external tick raises the timer interrupt line of every processor. Each processor drops its own timer line with a clear bit in a later write.

A read returns the stored status fields with the two-bit identity of the reading processor merged into the low bits. Only full 64-bit accesses are legal. A malformed access has no effect on the stored state and produces a one-cycle error pulse instead.

Top module: `ipi_tick_ctl`

## Requirements
- R1: After reset every IPI line, every timer line and the error pulse are low, all pending counts are zero, and a legal read returns only the reader's identity in bits 1:0.
- R2: A legal write with bit 12+i set adds one to the pending count of processor i. In the cycle after the write, `ipi_irq[i]` is high and status bit 8+i reads as 1.
- R3: A legal write with bit 8+i set takes one from a nonzero pending count of processor i. `ipi_irq[i]` and status bit 8+i drop only when the count reaches zero. A clear with a zero count changes nothing.
- R4: A pending count stops at 15. After 16 or more requests, the 15th clear drops the line.
- R5: When one write both requests and clears the same processor, the request is applied first and the clear second. The count is therefore unchanged, except at 15, where it ends at 14. At zero the line stays low.
- R6: A cycle with `tick` high raises `tmr_irq` and status bit 4+i for every processor. A line that is already high stays high.
- R7: A legal write with bit 4+i set drops `tmr_irq[i]` in the next cycle. If `tick` is high in the same cycle, the tick wins and the line stays high.
- R8: A read with `rd_size` = 3 (64-bit) loads `rd_data` in the next cycle. The value holds the timer status in bits 7:4, the IPI status in bits 11:8, zeros elsewhere, and `rd_cpu` ORed into bits 1:0. It shows the state before a write in the same cycle. Without a read, `rd_data` holds its value.
- R9: A legal write whose only recognised bit is bit 28 is accepted with no state change and no error pulse.
- R10: A 64-bit write with none of bits 4 to 15 and none of bit 28 set changes nothing and raises `acc_err` for exactly one cycle.
- R11: Size codes 0, 1 and 2 (8, 16 and 32 bits) are illegal. Such a write changes nothing, such a read loads zero into `rd_data`, and either one raises `acc_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Write access size code, 3 = 64-bit |
| wr_data | input | 64 | Write data with set and clear fields |
| rd_en | input | 1 | Read strobe |
| rd_size | input | 2 | Read access size code, 3 = 64-bit |
| rd_cpu | input | 2 | Identity of the reading processor |
| tick | input | 1 | Periodic timer tick |
| ipi_irq | output | 4 | IPI line per processor |
| tmr_irq | output | 4 | Timer interrupt line per processor |
| rd_data | output | 64 | Registered read data |
| acc_err | output | 1 | One-cycle pulse for an unsupported access |

## Verification
The bench sweeps every combination of the twelve set and clear bits, with ticks and reads mixed in, and compares each cycle against an arithmetic model of the counts and flags.

Three sets of corner cases get directed tests:
- Counter edges. The bench requests one processor 17 times and then clears it down. A counter that wrapped would drop the line after one clear. A counter that did not stop at 15 would need more clears than 15.
- Same-cycle collisions. These are a request and a clear in one write, and a tick together with a timer clear. A design with the wrong order would lose the IPI or drop the timer line.
- Illegal accesses. These are bad sizes and writes with no recognised field. A design that still decoded their fields would show changed lines or read data.

// File: rtl/ipi_tick_pkg.sv
package ipi_tick_pkg;

    localparam int NCPU        = 4;
    localparam int DATA_W      = 64;
    localparam int TMR_CLR_LO  = 4;
    localparam int IPI_CLR_LO  = 8;
    localparam int IPI_SET_LO  = 12;
    localparam int ACCEPT_BIT  = 28;
    localparam int TMR_STAT_LO = 4;
    localparam int IPI_STAT_LO = 8;
    localparam int ID_W        = 2;

    typedef enum logic [1:0] {
        ACC_B8  = 2'd0,
        ACC_B16 = 2'd1,
        ACC_B32 = 2'd2,
        ACC_B64 = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic            apply;
        logic [NCPU-1:0] ipi_set;
        logic [NCPU-1:0] ipi_clr;
        logic [NCPU-1:0] tmr_clr;
    } wr_cmd_t;

endpackage

// File: rtl/ipi_acc_dec.sv
module ipi_acc_dec
    import ipi_tick_pkg::*;
(
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_size,
    output wr_cmd_t           cmd,
    output logic              rd_ok,
    output logic              err_now
);

    logic wr_sized;
    logic recognised;
    logic unused_data;

    assign unused_data = ^{wr_data[DATA_W-1:ACCEPT_BIT+1],
                           wr_data[ACCEPT_BIT-1:IPI_SET_LO+NCPU],
                           wr_data[TMR_CLR_LO-1:0]};

    always_comb begin
        wr_sized   = wr_en && (acc_size_e'(wr_size) == ACC_B64);
        recognised = (|wr_data[IPI_SET_LO+NCPU-1:TMR_CLR_LO]) || wr_data[ACCEPT_BIT];
        rd_ok      = rd_en && (acc_size_e'(rd_size) == ACC_B64);

        cmd.apply   = wr_sized && recognised;
        cmd.ipi_set = cmd.apply ? wr_data[IPI_SET_LO +: NCPU] : '0;
        cmd.ipi_clr = cmd.apply ? wr_data[IPI_CLR_LO +: NCPU] : '0;
        cmd.tmr_clr = cmd.apply ? wr_data[TMR_CLR_LO +: NCPU] : '0;

        err_now = (wr_en && !(wr_sized && recognised)) || (rd_en && !rd_ok);
    end

endmodule

// File: rtl/ipi_pend_ctr.sv
module ipi_pend_ctr #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } pend_t;

    pend_t st_d, st_q;
    logic [CNT_W-1:0] after_set;

    always_comb begin
        after_set = st_q.cnt;
        if (set_i && (st_q.cnt != CNT_MAX)) after_set = st_q.cnt + 1'b1;
        st_d.cnt  = after_set;
        if (clr_i && (after_set != '0)) st_d.cnt = after_set - 1'b1;
        st_d.flag = st_q.flag || set_i;
        if (clr_i && (st_d.cnt == '0)) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.flag;

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic irq_o
);

    logic act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (clr_i)  act_d = 1'b0;
        if (tick_i) act_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    assign irq_o = act_q;

endmodule

// File: rtl/ipi_tick_ctl.sv
module ipi_tick_ctl
    import ipi_tick_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_size,
    input  logic [ID_W-1:0]   rd_cpu,
    input  logic              tick,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   tmr_irq,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err
);

    typedef struct packed {
        logic [DATA_W-1:0] rdat;
        logic              err;
    } port_t;

    wr_cmd_t           cmd;
    logic              rd_ok;
    logic              err_now;
    logic [DATA_W-1:0] status;
    port_t             po_d, po_q;

    ipi_acc_dec u_dec (
        .wr_en   (wr_en),
        .wr_size (wr_size),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_size (rd_size),
        .cmd     (cmd),
        .rd_ok   (rd_ok),
        .err_now (err_now)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        ipi_pend_ctr #(.CNT_W(CNT_W)) u_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (cmd.ipi_set[g]),
            .clr_i (cmd.ipi_clr[g]),
            .irq_o (ipi_irq[g])
        );
        tmr_flag u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .clr_i  (cmd.tmr_clr[g]),
            .irq_o  (tmr_irq[g])
        );
    end

    always_comb begin
        status = '0;
        status[TMR_STAT_LO +: NCPU] = tmr_irq;
        status[IPI_STAT_LO +: NCPU] = ipi_irq;

        po_d.err  = err_now;
        po_d.rdat = po_q.rdat;
        if (rd_en) begin
            po_d.rdat = '0;
            if (rd_ok) po_d.rdat = status | {{(DATA_W-ID_W){1'b0}}, rd_cpu};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) po_q <= '0;
        else        po_q <= po_d;
    end

    assign rd_data = po_q.rdat;
    assign acc_err = po_q.err;

endmodule

// File: rtl/ipi_tick_ctl_chk.sv
module ipi_tick_ctl_chk
    import ipi_tick_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_size,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [1:0]        rd_size,
    input logic [ID_W-1:0]   rd_cpu,
    input logic              tick,
    input logic [NCPU-1:0]   ipi_irq,
    input logic [NCPU-1:0]   tmr_irq,
    input logic [DATA_W-1:0] rd_data,
    input logic              acc_err
);

    for (genvar i = 0; i < NCPU; i++) begin : g_p
        AST_IPI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ipi_irq[i]) |-> $past(wr_en && wr_size == 2'd3 && wr_data[IPI_SET_LO+i])); // R2
        AST_IPI_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ipi_irq[i]) |-> $past(wr_en && wr_size == 2'd3 && wr_data[IPI_CLR_LO+i])); // R3
        AST_TMR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tmr_irq[i]) |-> $past(tick)); // R6
        AST_TMR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tmr_irq[i]) |-> $past(wr_en && wr_size == 2'd3 && wr_data[TMR_CLR_LO+i] && !tick)); // R7
    end

    AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size != 2'd3 && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq))); // R11
    AST_RD_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size == 2'd3) |=> (rd_data[1:0] == $past(rd_cpu))); // R8
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(wr_en || rd_en)); // R10

endmodule

bind ipi_tick_ctl ipi_tick_ctl_chk u_chk (.*);

// File: tb/ipi_tick_ctl_bench.sv
`timescale 1ns/1ps
module ipi_tick_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_size = 2'd0;
    logic [1:0]  rd_cpu = 2'd0;
    logic        tick = 1'b0;
    logic [3:0]  ipi_irq, tmr_irq;
    logic [63:0] rd_data;
    logic        acc_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int         m_cnt [4];
    logic [3:0] m_ipi, m_tmr;
    logic [63:0] m_rd;

    always #2 clk = ~clk;

    ipi_tick_ctl u_ipi_tick_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
        .wr_data(wr_data), .rd_en(rd_en), .rd_size(rd_size), .rd_cpu(rd_cpu),
        .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .rd_data(rd_data), .acc_err(acc_err)
    );

    task automatic check(input string req, input logic [75:0] act, input logic [75:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input string req, input logic we, input logic [63:0] d,
                      input logic [1:0] ws, input logic re, input logic [1:0] rs,
                      input logic [1:0] cpu, input logic tk);
        logic legal_w, rec, e_err;
        @(negedge clk);
        wr_en = we; wr_data = d; wr_size = ws;
        rd_en = re; rd_size = rs; rd_cpu = cpu; tick = tk;
        if (re) m_rd = (rs == 2'd3) ? ({52'd0, m_ipi, m_tmr, 4'd0} | {62'd0, cpu}) : 64'd0;
        legal_w = we && ws == 2'd3;
        rec     = (d[15:4] != 12'd0) || d[28];
        e_err   = (we && !(legal_w && rec)) || (re && rs != 2'd3);
        if (legal_w && rec) begin
            for (int i = 0; i < 4; i++) begin
                if (d[12+i]) begin
                    if (m_cnt[i] < 15) m_cnt[i]++;
                    m_ipi[i] = 1'b1;
                end
                if (d[8+i] && m_cnt[i] > 0) begin
                    m_cnt[i]--;
                    if (m_cnt[i] == 0) m_ipi[i] = 1'b0;
                end
                if (d[4+i]) m_tmr[i] = 1'b0;
            end
        end
        if (tk) m_tmr = 4'hF;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
        check(req, {ipi_irq, tmr_irq, acc_err, 3'd0, rd_data},
                   {m_ipi, m_tmr, e_err, 3'd0, m_rd});
    endtask

    task automatic wr(input string req, input logic [63:0] d);
        op(req, 1'b1, d, 2'd3, 1'b0, 2'd3, 2'd0, 1'b0);
    endtask

    initial begin
        repeat (5000000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_ipi = '0; m_tmr = '0; m_rd = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state and identity-only read
        @(negedge clk);
        check("R1", {ipi_irq, tmr_irq, acc_err, 3'd0, rd_data}, 76'd0);
        op("R1", 1'b0, 64'd0, 2'd3, 1'b1, 2'd3, 2'd2, 1'b0);
        // R2 R3 R4 per-processor count up past saturation and back
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 17; k++) wr("R2 R4", 64'd1 << (12 + c));
            for (int k = 0; k < 16; k++) wr("R3 R4", 64'd1 << (8 + c));
        end
        // R3 clear at zero ignored
        wr("R3", 64'h0000_0F00);
        // R5 same-write set and clear at 0, at 3, at 15
        wr("R5", 64'h0000_1100);
        for (int k = 0; k < 3; k++) wr("R5", 64'h0000_2000);
        wr("R5", 64'h0000_2200);
        for (int k = 0; k < 3; k++) wr("R5", 64'h0000_0200);
        for (int k = 0; k < 15; k++) wr("R5", 64'h0000_4000);
        wr("R5", 64'h0000_4400);
        for (int k = 0; k < 14; k++) wr("R5", 64'h0000_0400);
        // R6 R7 tick, clears, collision
        op("R6", 1'b0, 64'd0, 2'd3, 1'b0, 2'd3, 2'd0, 1'b1);
        op("R6", 1'b0, 64'd0, 2'd3, 1'b0, 2'd3, 2'd0, 1'b1);
        wr("R7", 64'h0000_0050);
        op("R7", 1'b1, 64'h0000_00A0, 2'd3, 1'b0, 2'd3, 2'd0, 1'b1);
        wr("R7", 64'h0000_00F0);
        // R8 reads from each identity, read during write
        wr("R8", 64'h0000_3000);
        op("R6", 1'b0, 64'd0, 2'd3, 1'b0, 2'd3, 2'd0, 1'b1);
        for (int c = 0; c < 4; c++) op("R8", 1'b0, 64'd0, 2'd3, 1'b1, 2'd3, 2'(c), 1'b0);
        op("R8", 1'b1, 64'h0000_0300, 2'd3, 1'b1, 2'd3, 2'd1, 1'b0);
        op("R8", 1'b0, 64'd0, 2'd3, 1'b0, 2'd3, 2'd0, 1'b0);
        // R9 accept-only write
        op("R9", 1'b1, 64'h1000_0000, 2'd3, 1'b1, 2'd3, 2'd3, 1'b0);
        // R10 unrecognised writes
        op("R10", 1'b1, 64'd0, 2'd3, 1'b1, 2'd3, 2'd0, 1'b0);
        op("R10", 1'b1, 64'hFFFF_FFFF_EFFF_000F, 2'd3, 1'b0, 2'd3, 2'd0, 1'b0);
        // R11 illegal sizes on write and read
        for (int s = 0; s < 3; s++) begin
            op("R11", 1'b1, 64'h0000_F0F0, 2'(s), 1'b0, 2'd3, 2'd0, 1'b0);
            op("R11", 1'b0, 64'd0, 2'd3, 1'b1, 2'(s), 2'd1, 1'b0);
        end
        // R2 R3 R5 R6 R7 R8 sweep over every combination of the set/clear fields
        for (int k = 0; k < 4096; k++) begin
            op("R2 R3 R5 R7 sweep", 1'b1, 64'(k) << 4, 2'd3, k[1], 2'd3,
               2'(k >> 2), k[0] ^ k[5]);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule